// File: doc/BRIEF.md
# Broadcast Coherence Home Controller

This block sits at the home node of a shared memory and serves coherence requests without keeping any sharer or owner record. Each read-shared, read-exclusive or flush request that it issues goes out as one probe to every processor node except the requester. In the same cycle, a read of the line starts on a fixed-latency memory port. When the read data returns, it goes to the requester as a response. The response also carries the number of probe acknowledgements that node must still collect, which is always the node count minus one.

Only one transaction per line is active at a time. A line is busy from the moment its request issues until the requester sends a completion for that line. Requests that cannot issue wait in a small hold queue and are replayed in strict arrival order. A request cannot issue if its line is busy, if earlier requests are already waiting, or if the busy-line table is full. A flush request locks its line more strongly: completions do not release it. Only a writeback that carries the flushed data releases the line, after the data has been written to memory.

The block is meant for a small cluster of nodes joined by an on-chip network. The node count, address and data widths, memory latency, hold queue depth and number of tracked busy lines are all parameters.

Top module: `bcast_home_ctrl`

## Requirements
- R1: After reset, no probe, response, memory read or memory write is driven, and `req_ready` is high.
- R2: Every issued request produces exactly one probe. Bit i of `probe_mask` stands for node i. The mask has every bit set except the requester's bit, which is clear.
- R3: `req_kind` is encoded as 2'b00 read-shared, 2'b01 read-exclusive, 2'b10 flush and 2'b11 reserved (handled as exclusive). `probe_excl` is 0 for read-shared and 1 for every other kind.
- R4: The memory read of the requested line is driven in the same cycle as its probe, with the same address. No read is driven without a probe.
- R5: The response goes to the requesting node `MEM_LAT`+1 cycles after the probe cycle. It carries the line address, the memory data of that line and `resp_acks` equal to `NODES`-1.
- R6: A request to a busy line is not probed until a completion for that line has been received. After that completion it is replayed.
- R7: Held requests issue in the order they were accepted, including requests to other, idle lines that arrived behind them.
- R8: A line locked by a flush request ignores completion messages and stays blocked.
- R9: A writeback to a flush-locked line writes its data to memory in the next cycle and releases the line. A request that was waiting for the line then receives the written data.
- R10: A writeback to a line that is not flush-locked is ignored, and no memory write occurs.
- R11: `req_ready` is low while the hold queue holds `HOLD_DEPTH` requests. It returns high once the queue drains.
- R12: A request accepted while its line is idle and the hold queue is empty is probed in the cycle right after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Coherence request present |
| req_ready | output | 1 | Request can be accepted (hold queue not full) |
| req_kind | input | 2 | Request kind, encoded as in R3 |
| req_node | input | $clog2(NODES) | Requesting node |
| req_addr | input | AW | Line address |
| cmp_valid | input | 1 | Requester signals end of its transaction |
| cmp_addr | input | AW | Line address of the completion |
| wb_valid | input | 1 | Flush writeback present (always accepted) |
| wb_addr | input | AW | Line address of the writeback |
| wb_data | input | DW | Flushed line data |
| probe_valid | output | 1 | Probe broadcast valid |
| probe_mask | output | NODES | Probe destination nodes |
| probe_addr | output | AW | Probed line address |
| probe_src | output | $clog2(NODES) | Node that made the request |
| probe_excl | output | 1 | Probe asks holders to invalidate |
| resp_valid | output | 1 | Data response valid |
| resp_node | output | $clog2(NODES) | Destination node of the response |
| resp_addr | output | AW | Line address of the response |
| resp_data | output | DW | Line data read from memory |
| resp_acks | output | $clog2(NODES) | Probe acknowledgements the requester must collect |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid `MEM_LAT` cycles after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
A request that is accepted while its line is idle and the hold queue is empty shows its probe and memory read in the cycle right after the accepting edge. The response follows exactly `MEM_LAT`+1 cycles after the probe, and a writeback's memory write appears one cycle after the writeback. A replayed request issues two cycles after the completion or writeback that frees its line. The monitor samples on the falling edge and stamps each probe with the cycle count. From that stamp it derives the cycle in which the matching response is due, and it compares that due cycle with the cycle in which the response actually arrives. Held requests are checked by counting the expected probes that are still outstanding after a waiting window. Any probe or write that has no expected entry is a failure.

// File: rtl/bcast_pkg.sv
`timescale 1ns/1ps
package bcast_pkg;

    // Request kinds; the encoding is visible at the req_kind port.
    typedef enum logic [1:0] {
        REQ_SHARED = 2'b00,
        REQ_EXCL   = 2'b01,
        REQ_FLUSH  = 2'b10,
        REQ_RSVD   = 2'b11
    } req_kind_e;

endpackage

// File: rtl/bcast_line_table.sv
`timescale 1ns/1ps
// Small associative table of lines that currently have a transaction in flight.
module bcast_line_table #(
    parameter int AW      = 8,
    parameter int ENTRIES = 4,
    parameter int NLOOK   = 4,
    parameter int NREL    = 2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NLOOK-1:0][AW-1:0]     look_addr,
    output logic [NLOOK-1:0]             look_hit,
    output logic [NLOOK-1:0]             look_flush,
    output logic [NLOOK-1:0][IDX_W-1:0]  look_idx,
    output logic                         has_free,
    input  logic                         alloc_en,
    input  logic [AW-1:0]                alloc_addr,
    input  logic                         alloc_flush,
    input  logic [NREL-1:0]              rel_en,
    input  logic [NREL-1:0][IDX_W-1:0]   rel_idx
);

    typedef struct packed {
        logic          vld;
        logic          flush;
        logic [AW-1:0] addr;
    } line_ent_t;

    line_ent_t [ENTRIES-1:0] tab_d, tab_q;
    logic [ENTRIES-1:0]      free_vec;
    logic [IDX_W-1:0]        alloc_idx;

    genvar ge, gl;
    generate
        for (ge = 0; ge < ENTRIES; ge++) begin : g_free
            assign free_vec[ge] = !tab_q[ge].vld;
        end

        for (gl = 0; gl < NLOOK; gl++) begin : g_look
            logic             hit_w;
            logic             fl_w;
            logic [IDX_W-1:0] idx_w;
            always_comb begin
                hit_w = 1'b0;
                fl_w  = 1'b0;
                idx_w = '0;
                for (int e = 0; e < ENTRIES; e++) begin
                    if (tab_q[e].vld && (tab_q[e].addr == look_addr[gl])) begin
                        hit_w = 1'b1;
                        fl_w  = tab_q[e].flush;
                        idx_w = IDX_W'(e);
                    end
                end
            end
            assign look_hit[gl]   = hit_w;
            assign look_flush[gl] = fl_w;
            assign look_idx[gl]   = idx_w;
        end
    endgenerate

    assign has_free = |free_vec;

    // Lowest free slot takes the next allocation.
    always_comb begin
        alloc_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (free_vec[e]) alloc_idx = IDX_W'(e);
        end
    end

    always_comb begin
        tab_d = tab_q;
        for (int r = 0; r < NREL; r++) begin
            if (rel_en[r]) tab_d[rel_idx[r]].vld = 1'b0;
        end
        if (alloc_en) begin
            tab_d[alloc_idx].vld   = 1'b1;
            tab_d[alloc_idx].flush = alloc_flush;
            tab_d[alloc_idx].addr  = alloc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

endmodule

// File: rtl/bcast_hold_fifo.sv
`timescale 1ns/1ps
// Arrival-order queue for requests that cannot issue yet.
module bcast_hold_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         empty,
    output logic         full
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.wp] = push_data;
            st_d.wp            = ptr_next(st_q.wp);
        end
        if (pop) st_d.rp = ptr_next(st_q.rp);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_data = st_q.slot[st_q.rp];
    assign empty     = (st_q.cnt == '0);
    assign full      = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/bcast_read_pipe.sv
`timescale 1ns/1ps
// Carries requester and line alongside the fixed-latency memory read.
module bcast_read_pipe #(
    parameter int NW  = 2,
    parameter int AW  = 8,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [NW-1:0] in_node,
    input  logic [AW-1:0] in_addr,
    output logic          out_vld,
    output logic [NW-1:0] out_node,
    output logic [AW-1:0] out_addr
);

    typedef struct packed {
        logic          vld;
        logic [NW-1:0] node;
        logic [AW-1:0] addr;
    } stage_t;

    // Stage 0 is loaded on the same edge as the memory read strobe,
    // so stage LAT lines up with the returning read data.
    stage_t [LAT:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0].vld  = in_vld;
        pipe_d[0].node = in_node;
        pipe_d[0].addr = in_addr;
        for (int k = 1; k <= LAT; k++) pipe_d[k] = pipe_q[k-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_vld  = pipe_q[LAT].vld;
    assign out_node = pipe_q[LAT].node;
    assign out_addr = pipe_q[LAT].addr;

endmodule

// File: rtl/bcast_home_ctrl.sv
`timescale 1ns/1ps
// Home-node controller: broadcast probes, overlapped memory read, line serialisation.
module bcast_home_ctrl
    import bcast_pkg::*;
#(
    parameter int NODES      = 4,
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int MEM_LAT    = 3,
    parameter int HOLD_DEPTH = 4,
    parameter int LINES      = 4,
    localparam int NW    = $clog2(NODES),
    localparam int ACK_W = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [NW-1:0]    req_node,
    input  logic [AW-1:0]    req_addr,
    input  logic             cmp_valid,
    input  logic [AW-1:0]    cmp_addr,
    input  logic             wb_valid,
    input  logic [AW-1:0]    wb_addr,
    input  logic [DW-1:0]    wb_data,
    output logic             probe_valid,
    output logic [NODES-1:0] probe_mask,
    output logic [AW-1:0]    probe_addr,
    output logic [NW-1:0]    probe_src,
    output logic             probe_excl,
    output logic             resp_valid,
    output logic [NW-1:0]    resp_node,
    output logic [AW-1:0]    resp_addr,
    output logic [DW-1:0]    resp_data,
    output logic [ACK_W-1:0] resp_acks,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wdata
);

    localparam int NLOOK = 4;   // head, incoming, completion, writeback
    localparam int LK_HEAD = 0;
    localparam int LK_REQ  = 1;
    localparam int LK_CMP  = 2;
    localparam int LK_WB   = 3;
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    typedef struct packed {
        logic [1:0]    kind;
        logic [NW-1:0] node;
        logic [AW-1:0] addr;
    } hold_t;
    localparam int HW = $bits(hold_t);

    typedef struct packed {
        logic             probe_valid;
        logic [NODES-1:0] probe_mask;
        logic [AW-1:0]    probe_addr;
        logic [NW-1:0]    probe_src;
        logic             probe_excl;
        logic             resp_valid;
        logic [NW-1:0]    resp_node;
        logic [AW-1:0]    resp_addr;
        logic [DW-1:0]    resp_data;
        logic [ACK_W-1:0] resp_acks;
        logic             mem_rd_en;
        logic [AW-1:0]    mem_rd_addr;
        logic             mem_wr_en;
        logic [AW-1:0]    mem_wr_addr;
        logic [DW-1:0]    mem_wdata;
    } out_st_t;

    out_st_t st_d, st_q;

    // ---- sub-block wiring -------------------------------------------------
    logic [NLOOK-1:0][AW-1:0]    look_addr;
    logic [NLOOK-1:0]            look_hit;
    logic [NLOOK-1:0]            look_flush;
    logic [NLOOK-1:0][IDX_W-1:0] look_idx;
    logic                        has_free;
    logic                        alloc_en;
    logic                        alloc_flush;
    logic [AW-1:0]               alloc_addr;
    logic [1:0]                  rel_en;
    logic [1:0][IDX_W-1:0]       rel_idx;

    logic [HW-1:0] head_raw;
    hold_t         head, req_ent, sel;
    logic          hq_empty, hq_full, hq_push, hq_pop;

    logic          ret_vld;
    logic [NW-1:0] ret_node;
    logic [AW-1:0] ret_addr;

    logic accept, use_head, direct, issue;
    logic [NODES-1:0] src_bit;

    assign head    = hold_t'(head_raw);
    assign req_ent = '{kind: req_kind, node: req_node, addr: req_addr};

    // ---- issue decision -------------------------------------------------
    always_comb begin
        look_addr[LK_HEAD] = head.addr;
        look_addr[LK_REQ]  = req_addr;
        look_addr[LK_CMP]  = cmp_addr;
        look_addr[LK_WB]   = wb_addr;

        accept   = req_valid && !hq_full;
        // Oldest held request goes first whenever its line is free.
        use_head = !hq_empty && !look_hit[LK_HEAD] && has_free;
        // New request bypasses the queue only when nothing waits ahead of it.
        direct   = accept && hq_empty && !look_hit[LK_REQ] && has_free;
        issue    = use_head || direct;
        hq_pop   = use_head;
        hq_push  = accept && !direct;
        sel      = use_head ? head : req_ent;

        alloc_en    = issue;
        alloc_addr  = sel.addr;
        alloc_flush = (sel.kind == REQ_FLUSH);

        // Completion frees an ordinary line; writeback frees a flush lock.
        rel_en[0]  = cmp_valid && look_hit[LK_CMP] && !look_flush[LK_CMP];
        rel_idx[0] = look_idx[LK_CMP];
        rel_en[1]  = wb_valid && look_hit[LK_WB] && look_flush[LK_WB];
        rel_idx[1] = look_idx[LK_WB];
    end

    // ---- registered outputs ----------------------------------------------
    always_comb begin
        src_bit = NODES'(1) << sel.node;

        st_d             = st_q;
        st_d.probe_valid = issue;
        st_d.mem_rd_en   = issue;
        if (issue) begin
            st_d.probe_mask  = ~src_bit;
            st_d.probe_addr  = sel.addr;
            st_d.probe_src   = sel.node;
            st_d.probe_excl  = (sel.kind != REQ_SHARED);
            st_d.mem_rd_addr = sel.addr;
        end

        st_d.mem_wr_en = rel_en[1];
        if (rel_en[1]) begin
            st_d.mem_wr_addr = wb_addr;
            st_d.mem_wdata   = wb_data;
        end

        st_d.resp_valid = ret_vld;
        if (ret_vld) begin
            st_d.resp_node = ret_node;
            st_d.resp_addr = ret_addr;
            st_d.resp_data = mem_rdata;
            st_d.resp_acks = ACK_W'(NODES - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready   = !hq_full;
    assign probe_valid = st_q.probe_valid;
    assign probe_mask  = st_q.probe_mask;
    assign probe_addr  = st_q.probe_addr;
    assign probe_src   = st_q.probe_src;
    assign probe_excl  = st_q.probe_excl;
    assign resp_valid  = st_q.resp_valid;
    assign resp_node   = st_q.resp_node;
    assign resp_addr   = st_q.resp_addr;
    assign resp_data   = st_q.resp_data;
    assign resp_acks   = st_q.resp_acks;
    assign mem_rd_en   = st_q.mem_rd_en;
    assign mem_rd_addr = st_q.mem_rd_addr;
    assign mem_wr_en   = st_q.mem_wr_en;
    assign mem_wr_addr = st_q.mem_wr_addr;
    assign mem_wdata   = st_q.mem_wdata;

    // ---- sub-blocks -------------------------------------------------------
    bcast_line_table #(
        .AW(AW), .ENTRIES(LINES), .NLOOK(NLOOK), .NREL(2)
    ) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_addr  (look_addr),
        .look_hit   (look_hit),
        .look_flush (look_flush),
        .look_idx   (look_idx),
        .has_free   (has_free),
        .alloc_en   (alloc_en),
        .alloc_addr (alloc_addr),
        .alloc_flush(alloc_flush),
        .rel_en     (rel_en),
        .rel_idx    (rel_idx)
    );

    bcast_hold_fifo #(
        .W(HW), .DEPTH(HOLD_DEPTH)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (hq_push),
        .push_data(req_ent),
        .pop      (hq_pop),
        .head_data(head_raw),
        .empty    (hq_empty),
        .full     (hq_full)
    );

    bcast_read_pipe #(
        .NW(NW), .AW(AW), .LAT(MEM_LAT)
    ) u_rpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (issue),
        .in_node (sel.node),
        .in_addr (sel.addr),
        .out_vld (ret_vld),
        .out_node(ret_node),
        .out_addr(ret_addr)
    );

endmodule

// File: rtl/bcast_home_ctrl_chk.sv
`timescale 1ns/1ps
module bcast_home_ctrl_chk #(
    parameter int NODES = 4,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int NW    = $clog2(NODES),
    localparam int ACK_W = $clog2(NODES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_valid,
    input logic [AW-1:0]    wb_addr,
    input logic [DW-1:0]    wb_data,
    input logic             probe_valid,
    input logic [NODES-1:0] probe_mask,
    input logic [AW-1:0]    probe_addr,
    input logic [NW-1:0]    probe_src,
    input logic             resp_valid,
    input logic [ACK_W-1:0] resp_acks,
    input logic             mem_rd_en,
    input logic [AW-1:0]    mem_rd_addr,
    input logic             mem_wr_en,
    input logic [AW-1:0]    mem_wr_addr,
    input logic [DW-1:0]    mem_wdata
);

    // R4
    probe_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid == mem_rd_en);

    // R4
    read_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> (mem_rd_addr == probe_addr));

    // R2
    probe_mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> (!probe_mask[probe_src] && ($countones(probe_mask) == NODES - 1)));

    // R5
    resp_ack_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_acks == ACK_W'(NODES - 1)));

    // R9
    write_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(wb_valid) && (mem_wr_addr == $past(wb_addr))
                       && (mem_wdata == $past(wb_data))));

endmodule

bind bcast_home_ctrl bcast_home_ctrl_chk #(
    .NODES(NODES), .AW(AW), .DW(DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_valid   (wb_valid),
    .wb_addr    (wb_addr),
    .wb_data    (wb_data),
    .probe_valid(probe_valid),
    .probe_mask (probe_mask),
    .probe_addr (probe_addr),
    .probe_src  (probe_src),
    .resp_valid (resp_valid),
    .resp_acks  (resp_acks),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .mem_wr_en  (mem_wr_en),
    .mem_wr_addr(mem_wr_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/test_bcast_home_ctrl.sv
`timescale 1ns/1ps
module test_bcast_home_ctrl;

    localparam int NODES = 4;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int LAT   = 3;
    localparam int HOLD  = 4;
    localparam int LINES = 4;
    localparam int NW    = $clog2(NODES);
    localparam int ACK_W = $clog2(NODES);
    localparam int MSIZE = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_kind = '0;
    logic [NW-1:0]    req_node = '0;
    logic [AW-1:0]    req_addr = '0;
    logic             cmp_valid = 1'b0;
    logic [AW-1:0]    cmp_addr = '0;
    logic             wb_valid = 1'b0;
    logic [AW-1:0]    wb_addr = '0;
    logic [DW-1:0]    wb_data = '0;
    logic             probe_valid;
    logic [NODES-1:0] probe_mask;
    logic [AW-1:0]    probe_addr;
    logic [NW-1:0]    probe_src;
    logic             probe_excl;
    logic             resp_valid;
    logic [NW-1:0]    resp_node;
    logic [AW-1:0]    resp_addr;
    logic [DW-1:0]    resp_data;
    logic [ACK_W-1:0] resp_acks;
    logic             mem_rd_en;
    logic [AW-1:0]    mem_rd_addr;
    logic [DW-1:0]    mem_rdata;
    logic             mem_wr_en;
    logic [AW-1:0]    mem_wr_addr;
    logic [DW-1:0]    mem_wdata;

    bcast_home_ctrl #(
        .NODES(NODES), .AW(AW), .DW(DW), .MEM_LAT(LAT),
        .HOLD_DEPTH(HOLD), .LINES(LINES)
    ) i_bcast_home_ctrl (.*);

    // ---- memory model --------------------------------------------------
    function automatic logic [DW-1:0] init_word(input int i);
        return (DW'(i) * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction

    logic [DW-1:0] mem [MSIZE];
    logic [DW-1:0] rpipe [1:LAT];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MSIZE; i++) mem[i] <= init_word(i);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wdata;
        end
        rpipe[1] <= mem[mem_rd_addr];
        for (int k = 2; k <= LAT; k++) rpipe[k] <= rpipe[k-1];
    end
    assign mem_rdata = rpipe[LAT];

    // ---- scoreboard ------------------------------------------------------
    typedef struct { logic [NW-1:0] node; logic [AW-1:0] addr; logic excl; } pexp_t;
    typedef struct { logic [NW-1:0] node; logic [AW-1:0] addr; logic [DW-1:0] data; int due; } rexp_t;
    typedef struct { logic [AW-1:0] addr; logic [DW-1:0] data; } wexp_t;

    pexp_t pq[$];
    rexp_t rq[$];
    wexp_t wq[$];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string rq_tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq_tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Monitor: samples on the falling edge.
    always @(negedge clk) begin
        pexp_t pe;
        rexp_t re;
        wexp_t we;
        logic [NODES-1:0] em;
        if (rst_n) begin
            if (probe_valid) begin
                if (pq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 unexpected probe: actual addr %0h src %0d, expected none",
                             probe_addr, probe_src);
                end else begin
                    pe = pq.pop_front();
                    em = ~(NODES'(1) << pe.node);
                    chk("R7", "probe addr", 64'(probe_addr), 64'(pe.addr));
                    chk("R7", "probe src", 64'(probe_src), 64'(pe.node));
                    chk("R3", "probe excl", 64'(probe_excl), 64'(pe.excl));
                    chk("R2", "probe mask", 64'(probe_mask), 64'(em));
                    chk("R4", "read with probe", 64'(mem_rd_en), 64'd1);
                    chk("R4", "read addr", 64'(mem_rd_addr), 64'(pe.addr));
                    rq.push_back('{node: pe.node, addr: pe.addr,
                                   data: mem[pe.addr], due: cyc + LAT + 1});
                end
            end else if (mem_rd_en) begin
                checks++; fails++;
                $display("FAIL R4 read without probe: actual 1 expected 0");
            end

            if (resp_valid) begin
                if (rq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R5 unexpected response: actual addr %0h expected none", resp_addr);
                end else begin
                    re = rq.pop_front();
                    chk("R5", "resp cycle", 64'(cyc), 64'(re.due));
                    chk("R5", "resp node", 64'(resp_node), 64'(re.node));
                    chk("R5", "resp addr", 64'(resp_addr), 64'(re.addr));
                    chk("R5", "resp data", 64'(resp_data), 64'(re.data));
                    chk("R5", "resp acks", 64'(resp_acks), 64'(NODES - 1));
                end
            end

            if (mem_wr_en) begin
                if (wq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R10 unexpected write: actual addr %0h expected none", mem_wr_addr);
                end else begin
                    we = wq.pop_front();
                    chk("R9", "write addr", 64'(mem_wr_addr), 64'(we.addr));
                    chk("R9", "write data", 64'(mem_wdata), 64'(we.data));
                end
            end
        end
    end

    // ---- driver tasks ----------------------------------------------------
    task automatic send_req(input int node, input int addr, input logic [1:0] kind);
        pq.push_back('{node: NW'(node), addr: AW'(addr), excl: (kind != 2'b00)});
        @(negedge clk);
        req_valid = 1'b1;
        req_node  = NW'(node);
        req_addr  = AW'(addr);
        req_kind  = kind;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_cmp(input int addr);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_addr  = AW'(addr);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic send_wb(input int addr, input logic [DW-1:0] data, input bit expect_write);
        if (expect_write) wq.push_back('{addr: AW'(addr), data: data});
        @(negedge clk);
        wb_valid = 1'b1;
        wb_addr  = AW'(addr);
        wb_data  = data;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 300; i++) begin
            if (pq.size() == 0 && rq.size() == 0 && wq.size() == 0) break;
            @(negedge clk);
        end
    endtask

    // ---- watchdog --------------------------------------------------------
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // ---- stimulus --------------------------------------------------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "probe_valid", 64'(probe_valid), 64'd0);
        chk("R1", "resp_valid", 64'(resp_valid), 64'd0);
        chk("R1", "mem_rd_en", 64'(mem_rd_en), 64'd0);
        chk("R1", "mem_wr_en", 64'(mem_wr_en), 64'd0);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);

        // R12 / R2 / R3 / R5: shared read on an idle line
        send_req(1, 'h10, 2'b00);
        chk("R12", "probe right after accept", 64'(probe_valid), 64'd1);
        drain();
        send_cmp('h10);

        // R3 exclusive and reserved kinds
        send_req(2, 'h20, 2'b01);
        drain();
        send_cmp('h20);
        send_req(0, 'h24, 2'b11);
        drain();
        send_cmp('h24);

        // R6: second request to a busy line waits for the completion
        send_req(0, 'h40, 2'b00);
        drain();
        send_req(3, 'h40, 2'b01);
        repeat (8) @(negedge clk);
        chk("R6", "held request not probed", 64'(pq.size()), 64'd1);
        send_cmp('h40);
        drain();
        chk("R6", "held request replayed", 64'(pq.size()), 64'd0);
        send_cmp('h40);

        // R7: idle-line request stays behind an older held one
        send_req(0, 'h50, 2'b00);
        send_req(3, 'h50, 2'b01);
        send_req(1, 'h60, 2'b00);
        repeat (LAT + 6) @(negedge clk);
        chk("R7", "both held", 64'(pq.size()), 64'd2);
        send_cmp('h50);
        drain();
        send_cmp('h50);
        send_cmp('h60);

        // R8 / R9: flush lock, ignored completion, writeback release
        send_req(2, 'h70, 2'b10);
        drain();
        send_cmp('h70);
        send_req(0, 'h70, 2'b00);
        repeat (8) @(negedge clk);
        chk("R8", "flush lock survives completion", 64'(pq.size()), 64'd1);
        send_wb('h70, 32'hCAFE_0070, 1'b1);
        drain();
        chk("R9", "flushed data in memory", 64'(mem['h70]), 64'(32'hCAFE_0070));
        send_cmp('h70);

        // R10: writeback to an unlocked line
        send_wb('h80, 32'h1234_5678, 1'b0);
        repeat (5) @(negedge clk);
        chk("R10", "memory unchanged", 64'(mem['h80]), 64'(init_word('h80)));

        // R11: hold queue fills and then drains
        send_req(1, 'h90, 2'b00);
        drain();
        for (int k = 0; k < HOLD; k++) send_req(k, 'h90, 2'b00);
        chk("R11", "ready low when full", 64'(req_ready), 64'd0);
        for (int k = 0; k <= HOLD; k++) begin
            send_cmp('h90);
            repeat (LAT + 5) @(negedge clk);
        end
        drain();
        chk("R11", "ready restored", 64'(req_ready), 64'd1);

        chk("R7", "no probe left pending", 64'(pq.size()), 64'd0);
        chk("R5", "no response left pending", 64'(rq.size()), 64'd0);
        chk("R9", "no write left pending", 64'(wq.size()), 64'd0);

        summary();
        $finish;
    end

endmodule